// File: doc/BRIEF.md
# Halfword Host Address and Data Sequencer

This block sits between a 16-bit host bus and the 32-bit address and data registers behind it. The host moves every 32-bit quantity as two successive halfwords. The block pairs them into whole words and lets the host read words back one halfword at a time. A single order input chooses whether the upper or the lower halfword travels first. The same choice governs address transfers and data transfers.

Two 32-bit address registers are kept: one for writes and one for reads. In single-address mode, one completed host address write loads both registers. In dual-address mode, a select input steers each host address access to one of them. The CPU side can load either register directly at any time. A synchronous hold-reset input freezes host traffic and returns every pairing tracker to the first-halfword position. Memory access and buffering are left to neighbouring blocks.

Top module: `hw_link_seq`

## Requirements
- R1: After `rst_n` is low at a clock edge, both address outputs are 0, `wword_vld` is 0, `host_rdata` is 0, and the next host access of every class is taken as a first halfword.
- R2: With `ord_lsb_first`=0, a data write pair places its first halfword in bits 31:16 and its second in bits 15:0. `wword` and a `wword_vld` high appear in the cycle after the second halfword is strobed.
- R3: With `ord_lsb_first`=1, the first halfword of a pair goes to bits 15:0 and the second to bits 31:16. This holds for data writes, address writes and both kinds of read.
- R4: `wword_vld` is high for exactly one cycle for each completed data-write pair, and it stays low after an unpaired first halfword.
- R5: With `dual_mode`=0, a completed host address write pair (`host_is_addr`=1) loads `waddr` and `raddr` with the same assembled value in the following cycle.
- R6: With `dual_mode`=1, a completed host address write loads only `waddr` when `sel_raddr`=0, and only `raddr` when `sel_raddr`=1. The other register keeps its value.
- R7: `cpu_ld_waddr` and `cpu_ld_raddr` load `cpu_addr` into their own register in the next cycle, in either mode. When a CPU load and a completing host address write target the same register in one cycle, the CPU value is kept.
- R8: A host address read returns one halfword on `host_rdata` in the cycle after the strobe. The source is `raddr` when `dual_mode`=1 and `sel_raddr`=1, and `waddr` otherwise. The first read of a pair gives the halfword selected by the order input, and the second read gives the other halfword.
- R9: A host data read returns halfwords of `rd_word` with the same ordering and timing as address reads. When an address read and a data read are strobed together, the address halfword is returned.
- R10: While `hold_rst` is high, host strobes are ignored: no register, word or valid changes. Every tracker goes back to the first-halfword position.
- R11: Address write, address read, data write and data read each keep their own pairing tracker. An access of one class never shifts the pairing of another class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_rst | input | 1 | Synchronous hold: blocks host strobes and clears trackers |
| host_wr | input | 1 | Host halfword write strobe |
| host_rd | input | 1 | Host halfword read strobe |
| host_is_addr | input | 1 | 1 = access targets an address register, 0 = data |
| host_wdata | input | 16 | Host write halfword |
| ord_lsb_first | input | 1 | 0 = upper halfword first, 1 = lower halfword first |
| dual_mode | input | 1 | 1 = separate read/write address registers for host |
| sel_raddr | input | 1 | In dual mode: 0 = write address register, 1 = read address register |
| cpu_ld_waddr | input | 1 | CPU load of the write address register |
| cpu_ld_raddr | input | 1 | CPU load of the read address register |
| cpu_addr | input | 32 | CPU address value |
| rd_word | input | 32 | Word offered for host data reads |
| waddr | output | 32 | Write address register |
| raddr | output | 32 | Read address register |
| wword | output | 32 | Assembled data write word |
| wword_vld | output | 1 | One-cycle valid for `wword` |
| host_rdata | output | 16 | Halfword returned to the host |

## Verification
Two functions can land in the same clock cycle. In the first, a host address pair completes while the CPU loads the same address register. The bench arranges this by asserting `cpu_ld_waddr` alongside the second address halfword in single mode. The CPU value must appear in `waddr` and the host value in `raddr`. In the second, data and address halfwords are interleaved. The bench checks that each class still pairs on its own and that neither word is corrupted.

// File: rtl/hw_link_pkg.sv
package hw_link_pkg;
  // Access classes, each with its own pairing tracker
  typedef enum logic [1:0] {
    CLS_AW = 2'd0,
    CLS_AR = 2'd1,
    CLS_DW = 2'd2,
    CLS_DR = 2'd3
  } acc_cls_e;

  localparam int unsigned NUM_CLS = 4;
endpackage

// File: rtl/hw_pair_track.sv
module hw_pair_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  output logic second_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) second_q <= 1'b0;
    else if (stb)      second_q <= ~second_q;
  end

  // R11: each strobe flips the pair position
  p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !clr) |=> (second_q != $past(second_q)));
  // R10: hold returns tracker to the first position
  p_clr_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !second_q);
endmodule

// File: rtl/hw_addr_bank.sv
module hw_addr_bank #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ld,
  input  logic [WORD_W-1:0] host_word,
  input  logic              dual_mode,
  input  logic              sel_raddr,
  input  logic              cpu_ld_w,
  input  logic              cpu_ld_r,
  input  logic [WORD_W-1:0] cpu_addr,
  output logic [WORD_W-1:0] waddr_q,
  output logic [WORD_W-1:0] raddr_q
);
  logic host_to_w, host_to_r;

  always_comb begin
    host_to_w = host_ld && (!dual_mode || !sel_raddr);
    host_to_r = host_ld && (!dual_mode ||  sel_raddr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr_q <= '0;
      raddr_q <= '0;
    end else begin
      if (cpu_ld_w)       waddr_q <= cpu_addr;
      else if (host_to_w) waddr_q <= host_word;
      if (cpu_ld_r)       raddr_q <= cpu_addr;
      else if (host_to_r) raddr_q <= host_word;
    end
  end

  // R5: single-mode host load leaves both registers equal
  p_single_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ld && !dual_mode && !cpu_ld_w && !cpu_ld_r) |=> (waddr_q == raddr_q));
  // R7: CPU load wins
  p_cpu_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ld_w |=> (waddr_q == $past(cpu_addr)));
  // R6: dual mode, write-select leaves read register untouched
  p_dual_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ld && dual_mode && !sel_raddr && !cpu_ld_r) |=> $stable(raddr_q));
endmodule

// File: rtl/hw_read_mux.sv
module hw_read_mux #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_stb,
  input  logic              ar_second,
  input  logic              dr_stb,
  input  logic              dr_second,
  input  logic              ord_lsb_first,
  input  logic              dual_mode,
  input  logic              sel_raddr,
  input  logic [WORD_W-1:0] waddr,
  input  logic [WORD_W-1:0] raddr,
  input  logic [WORD_W-1:0] rd_word,
  output logic [HALF_W-1:0] rdata_q
);
  // Upper half is sent when pair position equals the order bit
  function automatic logic [HALF_W-1:0] pick_half(
    input logic [WORD_W-1:0] w, input logic second, input logic ord);
    return (second == ord) ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  logic [WORD_W-1:0] addr_src;
  assign addr_src = (dual_mode && sel_raddr) ? raddr : waddr;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (ar_stb) rdata_q <= pick_half(addr_src, ar_second, ord_lsb_first);
    else if (dr_stb) rdata_q <= pick_half(rd_word, dr_second, ord_lsb_first);
  end

  // R8: read data only moves on a read strobe
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ar_stb && !dr_stb) |=> $stable(rdata_q));
endmodule

// File: rtl/hw_link_seq.sv
module hw_link_seq
  import hw_link_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_is_addr,
  input  logic [HALF_W-1:0] host_wdata,
  input  logic              ord_lsb_first,
  input  logic              dual_mode,
  input  logic              sel_raddr,
  input  logic              cpu_ld_waddr,
  input  logic              cpu_ld_raddr,
  input  logic [WORD_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] waddr,
  output logic [WORD_W-1:0] raddr,
  output logic [WORD_W-1:0] wword,
  output logic              wword_vld,
  output logic [HALF_W-1:0] host_rdata
);
  // Place first/second halfword according to order bit
  function automatic logic [WORD_W-1:0] join_pair(
    input logic [HALF_W-1:0] first, input logic [HALF_W-1:0] second,
    input logic ord);
    return ord ? {second, first} : {first, second};
  endfunction

  logic [NUM_CLS-1:0] cls_stb;
  logic [NUM_CLS-1:0] cls_second;
  logic               go;

  assign go = !hold_rst;

  always_comb begin
    cls_stb         = '0;
    cls_stb[CLS_AW] = go && host_wr &&  host_is_addr;
    cls_stb[CLS_DW] = go && host_wr && !host_is_addr;
    cls_stb[CLS_AR] = go && host_rd &&  host_is_addr;
    cls_stb[CLS_DR] = go && host_rd && !host_is_addr;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_trk
    hw_pair_track u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hold_rst),
      .stb      (cls_stb[c]),
      .second_q (cls_second[c])
    );
  end

  // First-halfword capture for the two write classes
  logic [HALF_W-1:0] aw_first_q, dw_first_q;
  logic              aw_done, dw_done;

  assign aw_done = cls_stb[CLS_AW] && cls_second[CLS_AW];
  assign dw_done = cls_stb[CLS_DW] && cls_second[CLS_DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_first_q <= '0;
      dw_first_q <= '0;
    end else begin
      if (cls_stb[CLS_AW] && !cls_second[CLS_AW]) aw_first_q <= host_wdata;
      if (cls_stb[CLS_DW] && !cls_second[CLS_DW]) dw_first_q <= host_wdata;
    end
  end

  logic [WORD_W-1:0] aw_word;
  assign aw_word = join_pair(aw_first_q, host_wdata, ord_lsb_first);

  hw_addr_bank #(.WORD_W(WORD_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ld   (aw_done),
    .host_word (aw_word),
    .dual_mode (dual_mode),
    .sel_raddr (sel_raddr),
    .cpu_ld_w  (cpu_ld_waddr),
    .cpu_ld_r  (cpu_ld_raddr),
    .cpu_addr  (cpu_addr),
    .waddr_q   (waddr),
    .raddr_q   (raddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wword     <= '0;
      wword_vld <= 1'b0;
    end else begin
      wword_vld <= dw_done;
      if (dw_done) wword <= join_pair(dw_first_q, host_wdata, ord_lsb_first);
    end
  end

  hw_read_mux #(.HALF_W(HALF_W)) u_rmux (
    .clk           (clk),
    .rst_n         (rst_n),
    .ar_stb        (cls_stb[CLS_AR]),
    .ar_second     (cls_second[CLS_AR]),
    .dr_stb        (cls_stb[CLS_DR]),
    .dr_second     (cls_second[CLS_DR]),
    .ord_lsb_first (ord_lsb_first),
    .dual_mode     (dual_mode),
    .sel_raddr     (sel_raddr),
    .waddr         (waddr),
    .raddr         (raddr),
    .rd_word       (rd_word),
    .rdata_q       (host_rdata)
  );

  // R10: no valid after a held cycle
  p_hold_no_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> !wword_vld);
  // R4: valid is a single-cycle pulse
  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wword_vld |=> !wword_vld || $past(host_wr && !host_is_addr && !hold_rst));
  // R10: held strobes leave address registers alone without CPU loads
  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rst && !cpu_ld_waddr && !cpu_ld_raddr) |=> ($stable(waddr) && $stable(raddr)));
endmodule

// File: tb/test_hw_link_seq.sv
`timescale 1ns/1ps
module test_hw_link_seq;
  logic        clk = 1'b0;
  logic        rst_n, hold_rst, host_wr, host_rd, host_is_addr;
  logic [15:0] host_wdata;
  logic        ord_lsb_first, dual_mode, sel_raddr, cpu_ld_waddr, cpu_ld_raddr;
  logic [31:0] cpu_addr, rd_word;
  logic [31:0] waddr, raddr, wword;
  logic        wword_vld;
  logic [15:0] host_rdata;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  hw_link_seq i_hw_link_seq (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .host_wr(host_wr),
    .host_rd(host_rd), .host_is_addr(host_is_addr), .host_wdata(host_wdata),
    .ord_lsb_first(ord_lsb_first), .dual_mode(dual_mode), .sel_raddr(sel_raddr),
    .cpu_ld_waddr(cpu_ld_waddr), .cpu_ld_raddr(cpu_ld_raddr), .cpu_addr(cpu_addr),
    .rd_word(rd_word), .waddr(waddr), .raddr(raddr), .wword(wword),
    .wword_vld(wword_vld), .host_rdata(host_rdata));

  function automatic logic [31:0] expect_pair(logic [15:0] a, logic [15:0] b, logic ord);
    logic [31:0] r;
    if (ord == 1'b0) r = {a, b};
    else begin r[15:0] = a; r[31:16] = b; end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One host cycle, starting and ending at a falling edge
  task automatic hcyc(input logic wr, input logic rd, input logic is_addr, input logic [15:0] d);
    host_wr = wr; host_rd = rd; host_is_addr = is_addr; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_is_addr = 1'b0; host_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1 waddr", waddr, 32'h0);
    chk("R1 raddr", raddr, 32'h0);
    chk("R1 vld", {31'b0, wword_vld}, 32'h0);
    chk("R1 rdata", {16'b0, host_rdata}, 32'h0);
  endtask

  task automatic t_data_order;
    ord_lsb_first = 1'b0;
    hcyc(1, 0, 0, 16'hA1B2);
    chk("R4 no vld after first", {31'b0, wword_vld}, 32'h0);
    hcyc(1, 0, 0, 16'hC3D4);
    chk("R2 vld", {31'b0, wword_vld}, 32'h1);
    chk("R2 word", wword, expect_pair(16'hA1B2, 16'hC3D4, 1'b0));
    @(negedge clk);
    chk("R4 pulse ends", {31'b0, wword_vld}, 32'h0);
    ord_lsb_first = 1'b1;
    hcyc(1, 0, 0, 16'hA1B2);
    hcyc(1, 0, 0, 16'hC3D4);
    chk("R3 word lsb first", wword, 32'hC3D4A1B2);
  endtask

  task automatic t_addr_write;
    ord_lsb_first = 1'b0; dual_mode = 1'b0;
    hcyc(1, 0, 1, 16'h1234);
    hcyc(1, 0, 1, 16'h5678);
    chk("R5 waddr", waddr, 32'h12345678);
    chk("R5 raddr", raddr, 32'h12345678);
    dual_mode = 1'b1; sel_raddr = 1'b0;
    hcyc(1, 0, 1, 16'h1111);
    hcyc(1, 0, 1, 16'h2222);
    chk("R6 waddr sel0", waddr, 32'h11112222);
    chk("R6 raddr kept", raddr, 32'h12345678);
    sel_raddr = 1'b1; ord_lsb_first = 1'b1;
    hcyc(1, 0, 1, 16'hAAAA);
    hcyc(1, 0, 1, 16'hBBBB);
    chk("R6 raddr sel1 R3 order", raddr, expect_pair(16'hAAAA, 16'hBBBB, 1'b1));
    chk("R6 waddr kept", waddr, 32'h11112222);
  endtask

  task automatic t_reads;
    dual_mode = 1'b1; sel_raddr = 1'b1; ord_lsb_first = 1'b0;
    hcyc(0, 1, 1, 16'h0);
    chk("R8 raddr first half", {16'b0, host_rdata}, 32'h0000BBBB);
    hcyc(0, 1, 1, 16'h0);
    chk("R8 raddr second half", {16'b0, host_rdata}, 32'h0000AAAA);
    sel_raddr = 1'b0; ord_lsb_first = 1'b1;
    hcyc(0, 1, 1, 16'h0);
    chk("R8 waddr lsb first", {16'b0, host_rdata}, 32'h00002222);
    hcyc(0, 1, 1, 16'h0);
    chk("R8 waddr msb second", {16'b0, host_rdata}, 32'h00001111);
    rd_word = 32'hDEADBEEF; ord_lsb_first = 1'b0;
    hcyc(0, 1, 0, 16'h0);
    chk("R9 data first", {16'b0, host_rdata}, 32'h0000DEAD);
    hcyc(0, 1, 0, 16'h0);
    chk("R9 data second", {16'b0, host_rdata}, 32'h0000BEEF);
  endtask

  task automatic t_interleave;
    dual_mode = 1'b0; ord_lsb_first = 1'b0;
    hcyc(1, 0, 0, 16'h0102);
    hcyc(1, 0, 1, 16'h7777);
    chk("R11 no vld on addr", {31'b0, wword_vld}, 32'h0);
    hcyc(1, 0, 0, 16'h0304);
    chk("R11 data vld", {31'b0, wword_vld}, 32'h1);
    chk("R11 data word", wword, 32'h01020304);
    hcyc(1, 0, 1, 16'h8888);
    chk("R11 addr word", waddr, 32'h77778888);
  endtask

  task automatic t_cpu;
    dual_mode = 1'b0; ord_lsb_first = 1'b0;
    cpu_addr = 32'hCAFE0001; cpu_ld_raddr = 1'b1;
    @(negedge clk);
    cpu_ld_raddr = 1'b0;
    chk("R7 cpu raddr", raddr, 32'hCAFE0001);
    chk("R7 waddr kept", waddr, 32'h77778888);
    hcyc(1, 0, 1, 16'h9999);
    cpu_addr = 32'h55555555; cpu_ld_waddr = 1'b1;
    hcyc(1, 0, 1, 16'hAAAA);
    cpu_ld_waddr = 1'b0;
    chk("R7 cpu wins waddr", waddr, 32'h55555555);
    chk("R7 host raddr", raddr, 32'h9999AAAA);
  endtask

  task automatic t_hold;
    ord_lsb_first = 1'b0; dual_mode = 1'b0;
    hcyc(1, 0, 0, 16'h1111);
    hold_rst = 1'b1;
    hcyc(1, 0, 0, 16'h2222);
    chk("R10 no vld in hold", {31'b0, wword_vld}, 32'h0);
    hcyc(1, 0, 1, 16'hEEEE);
    hcyc(1, 0, 1, 16'hFFFF);
    chk("R10 addr unchanged", waddr, 32'h55555555);
    hold_rst = 1'b0;
    hcyc(1, 0, 0, 16'h3333);
    chk("R10 tracker at first", {31'b0, wword_vld}, 32'h0);
    hcyc(1, 0, 0, 16'h4444);
    chk("R10 word after hold", wword, 32'h33334444);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold_rst = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_is_addr = 1'b0; host_wdata = '0; ord_lsb_first = 1'b0;
    dual_mode = 1'b0; sel_raddr = 1'b0; cpu_ld_waddr = 1'b0;
    cpu_ld_raddr = 1'b0; cpu_addr = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_data_order();
    t_addr_write();
    t_reads();
    t_interleave();
    t_cpu();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule